// File: doc/BRIEF.md
# Paged Program Counter with Table Branch

This block holds the 12-bit instruction address of a small 4-bit controller, along with the two 4-bit registers that table lookups use. The address has two parts. The top bit is a page register that is stored on its own. The lower eleven bits form a counter that steps forward as instructions run. Because the page bit sits outside the counter, stepping forward never leaves the current 2K half of the 4K program space. Only an absolute jump or a return can move the address to the other half.

The block receives decoded control strobes from the instruction decoder and a byte of program memory data. It loads the address from four sources: a jump or call target, a value popped from the stack, a table offset, or its own increment. A table jump keeps the upper four address bits and takes the low byte from the pair formed by the table register (high nibble) and the accumulator (low nibble). A table return splits a fetched ROM byte into that same pair. The decoder, the program memory and the return stack are outside the block.

Top module: `pcb_paged_pc`

## Requirements
- R1: A synchronous active-high reset sets the address, the table register and the accumulator to zero. Reset takes priority over every strobe.
- R2: An increment adds one to address bits 10..0 and leaves bit 11 (the page) unchanged.
- R3: Incrementing from offset 0x7FF within a page wraps to offset 0x000 of the same page. So 0x7FF becomes 0x000 and 0xFFF becomes 0x800.
- R4: A jump loads all 12 target bits, including the page bit, so it can reach any address from 0x000 to 0xFFF.
- R5: A call loads target bits 10..0 and keeps the current page bit.
- R6: A return loads all 12 bits of the return address input.
- R7: A table jump sets the address to {address[11:8], table register, accumulator}. It uses the register values from before that clock edge.
- R8: A table return loads ROM data bits 7..4 into the table register and bits 3..0 into the accumulator. It does not change the address.
- R9: When several address strobes are active in one cycle, the winner is chosen in this order: return, then jump, then call, then table jump, then increment.
- R10: With no address strobe the address holds its value. Without a table return, the table register and the accumulator hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inc_en | input | 1 | Step the address forward within its page |
| jmp_en | input | 1 | Load the full 12-bit target, page included |
| call_en | input | 1 | Load target bits 10..0 and keep the page |
| ret_en | input | 1 | Load the popped return address |
| tjmp_en | input | 1 | Table jump through the register pair |
| trtn_en | input | 1 | Split rom_data into the register pair |
| tgt_addr | input | 12 | Jump or call target |
| ret_addr | input | 12 | Return address from the stack |
| rom_data | input | 8 | Fetched program byte for a table return |
| pc | output | 12 | Current program address |
| tbr | output | 4 | Table register (high offset nibble) |
| ac | output | 4 | Accumulator (low offset nibble) |

## Verification
Every piece of state appears directly on an output. A wrong page bit, counter value or register nibble therefore shows on `pc`, `tbr` or `ac` in the first cycle after the edge that caused it. A priority error shows only when strobes overlap, so such overlaps are driven both on purpose and at random. A table jump reads the pair, which means an earlier error in a table return also shows up again later as a wrong low address byte.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

    localparam int PC_W   = 12;
    localparam int PG_W   = 1;
    localparam int CNT_W  = PC_W - PG_W;
    localparam int NIB_W  = 4;
    localparam int OFS_W  = 2 * NIB_W;
    localparam int KEEP_W = CNT_W - OFS_W;

    typedef logic [PC_W-1:0]  pc_t;
    typedef logic [PG_W-1:0]  page_t;
    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [OFS_W-1:0] ofs_t;

    typedef struct packed {
        page_t page;
        cnt_t  cnt;
    } pc_s;

    typedef struct packed {
        nib_t hi;
        nib_t lo;
    } tbl_pair_s;

    typedef enum logic [2:0] {
        SRC_HOLD = 3'd0,
        SRC_INC  = 3'd1,
        SRC_TJMP = 3'd2,
        SRC_CALL = 3'd3,
        SRC_JMP  = 3'd4,
        SRC_RET  = 3'd5
    } src_e;

    function automatic src_e pick_src(input logic ret_en, input logic jmp_en,
                                      input logic call_en, input logic tjmp_en,
                                      input logic inc_en);
        src_e s;
        if (ret_en)       s = SRC_RET;
        else if (jmp_en)  s = SRC_JMP;
        else if (call_en) s = SRC_CALL;
        else if (tjmp_en) s = SRC_TJMP;
        else if (inc_en)  s = SRC_INC;
        else              s = SRC_HOLD;
        return s;
    endfunction

    function automatic page_t page_of(input pc_t a);
        pc_s v;
        v = pc_s'(a);
        return v.page;
    endfunction

    function automatic cnt_t cnt_of(input pc_t a);
        pc_s v;
        v = pc_s'(a);
        return v.cnt;
    endfunction

endpackage

// File: rtl/pcb_src_sel.sv
module pcb_src_sel
    import pcb_pkg::*;
(
    input  logic ret_en,
    input  logic jmp_en,
    input  logic call_en,
    input  logic tjmp_en,
    input  logic inc_en,
    output src_e src
);

    always_comb begin
        src = pick_src(ret_en, jmp_en, call_en, tjmp_en, inc_en);
    end

endmodule

// File: rtl/pcb_page_reg.sv
module pcb_page_reg
    import pcb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  src_e  src,
    input  page_t tgt_page,
    input  page_t ret_page,
    output page_t page_q
);

    page_t page_d;

    always_comb begin
        case (src)
            SRC_RET: page_d = ret_page;
            SRC_JMP: page_d = tgt_page;
            default: page_d = page_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) page_q <= '0;
        else     page_q <= page_d;
    end

    // page stays put for every source except return and jump
    assert_page_kept_R2: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_INC || src == SRC_CALL || src == SRC_TJMP || src == SRC_HOLD)
        |=> $stable(page_q));

endmodule

// File: rtl/pcb_seq_counter.sv
module pcb_seq_counter
    import pcb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  src_e src,
    input  cnt_t tgt_cnt,
    input  cnt_t ret_cnt,
    input  ofs_t tbl_ofs,
    output cnt_t cnt_q
);

    cnt_t cnt_d;
    logic [KEEP_W-1:0] keep_bits;

    assign keep_bits = cnt_q[CNT_W-1:OFS_W];

    always_comb begin
        case (src)
            SRC_RET:  cnt_d = ret_cnt;
            SRC_JMP:  cnt_d = tgt_cnt;
            SRC_CALL: cnt_d = tgt_cnt;
            SRC_TJMP: cnt_d = {keep_bits, tbl_ofs};
            SRC_INC:  cnt_d = cnt_q + cnt_t'(1);
            default:  cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assert_inc_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_INC && cnt_q == '1) |=> (cnt_q == '0));

    assert_cnt_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_HOLD) |=> $stable(cnt_q));

endmodule

// File: rtl/pcb_table_regs.sv
module pcb_table_regs
    import pcb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trtn_en,
    input  ofs_t rom_byte,
    output nib_t tbr_q,
    output nib_t ac_q
);

    tbl_pair_s pair_q;

    always_ff @(posedge clk) begin
        if (rst)          pair_q <= '0;
        else if (trtn_en) pair_q <= tbl_pair_s'(rom_byte);
    end

    assign tbr_q = pair_q.hi;
    assign ac_q  = pair_q.lo;

    assert_trtn_split_R8: assert property (@(posedge clk) disable iff (rst)
        trtn_en |=> (tbr_q == $past(rom_byte[OFS_W-1:NIB_W]) &&
                     ac_q  == $past(rom_byte[NIB_W-1:0])));

    assert_pair_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !trtn_en |=> ($stable(tbr_q) && $stable(ac_q)));

endmodule

// File: rtl/pcb_paged_pc.sv
module pcb_paged_pc
    import pcb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            inc_en,
    input  logic            jmp_en,
    input  logic            call_en,
    input  logic            ret_en,
    input  logic            tjmp_en,
    input  logic            trtn_en,
    input  logic [PC_W-1:0] tgt_addr,
    input  logic [PC_W-1:0] ret_addr,
    input  logic [OFS_W-1:0] rom_data,
    output logic [PC_W-1:0] pc,
    output logic [NIB_W-1:0] tbr,
    output logic [NIB_W-1:0] ac
);

    src_e  src;
    page_t page_q;
    cnt_t  cnt_q;
    nib_t  tbr_q;
    nib_t  ac_q;
    pc_s   pc_view;

    pcb_src_sel u_src_sel (
        .ret_en  (ret_en),
        .jmp_en  (jmp_en),
        .call_en (call_en),
        .tjmp_en (tjmp_en),
        .inc_en  (inc_en),
        .src     (src)
    );

    pcb_page_reg u_page_reg (
        .clk      (clk),
        .rst      (rst),
        .src      (src),
        .tgt_page (page_of(tgt_addr)),
        .ret_page (page_of(ret_addr)),
        .page_q   (page_q)
    );

    pcb_seq_counter u_seq_counter (
        .clk     (clk),
        .rst     (rst),
        .src     (src),
        .tgt_cnt (cnt_of(tgt_addr)),
        .ret_cnt (cnt_of(ret_addr)),
        .tbl_ofs ({tbr_q, ac_q}),
        .cnt_q   (cnt_q)
    );

    pcb_table_regs u_table_regs (
        .clk      (clk),
        .rst      (rst),
        .trtn_en  (trtn_en),
        .rom_byte (rom_data),
        .tbr_q    (tbr_q),
        .ac_q     (ac_q)
    );

    always_comb begin
        pc_view.page = page_q;
        pc_view.cnt  = cnt_q;
    end

    assign pc  = pc_t'(pc_view);
    assign tbr = tbr_q;
    assign ac  = ac_q;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (pc == '0 && tbr == '0 && ac == '0));

    assert_ret_load_R6: assert property (@(posedge clk) disable iff (rst)
        ret_en |=> (pc == $past(ret_addr)));

    assert_jmp_full_R4: assert property (@(posedge clk) disable iff (rst)
        (jmp_en && !ret_en) |=> (pc == $past(tgt_addr)));

    assert_call_page_R5: assert property (@(posedge clk) disable iff (rst)
        (call_en && !jmp_en && !ret_en) |=>
        (pc[PC_W-1] == $past(pc[PC_W-1]) && pc[CNT_W-1:0] == $past(tgt_addr[CNT_W-1:0])));

    assert_tjmp_target_R7: assert property (@(posedge clk) disable iff (rst)
        (tjmp_en && !call_en && !jmp_en && !ret_en) |=>
        (pc == {$past(pc[PC_W-1:OFS_W]), $past(tbr), $past(ac)}));

    assert_inc_step_R9: assert property (@(posedge clk) disable iff (rst)
        (inc_en && !tjmp_en && !call_en && !jmp_en && !ret_en && pc[CNT_W-1:0] != '1) |=>
        (pc == $past(pc) + pc_t'(1)));

endmodule

// File: tb/test_pcb_paged_pc.sv
module test_pcb_paged_pc;

    logic        clk = 1'b0;
    logic        rst;
    logic        inc_en, jmp_en, call_en, ret_en, tjmp_en, trtn_en;
    logic [11:0] tgt_addr, ret_addr;
    logic [7:0]  rom_data;
    logic [11:0] pc;
    logic [3:0]  tbr, ac;

    int total = 0;
    int bad   = 0;
    int m_pc  = 0;
    int m_tbr = 0;
    int m_ac  = 0;
    string req = "R1";
    string last_req = "R1";

    always #2 clk = ~clk;

    pcb_paged_pc i_pcb_paged_pc (
        .clk(clk), .rst(rst), .inc_en(inc_en), .jmp_en(jmp_en), .call_en(call_en),
        .ret_en(ret_en), .tjmp_en(tjmp_en), .trtn_en(trtn_en), .tgt_addr(tgt_addr),
        .ret_addr(ret_addr), .rom_data(rom_data), .pc(pc), .tbr(tbr), .ac(ac)
    );

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        int np;
        if (rst) begin
            m_pc = 0; m_tbr = 0; m_ac = 0;
        end else begin
            np = m_pc;
            if (ret_en)       np = int'(ret_addr);
            else if (jmp_en)  np = int'(tgt_addr);
            else if (call_en) np = (m_pc & 'h800) | (int'(tgt_addr) & 'h7FF);
            else if (tjmp_en) np = (m_pc & 'hF00) | (m_tbr << 4) | m_ac;
            else if (inc_en)  np = (m_pc & 'h800) | ((m_pc + 1) & 'h7FF);
            if (trtn_en) begin
                m_tbr = (int'(rom_data) >> 4) & 'hF;
                m_ac  = int'(rom_data) & 'hF;
            end
            m_pc = np;
        end
    end

    task automatic compare();
        total++;
        if (int'(pc) != m_pc || int'(tbr) != m_tbr || int'(ac) != m_ac) begin
            bad++;
            $display("FAIL %s: pc=%03h tbr=%h ac=%h expected pc=%03h tbr=%h ac=%h",
                     last_req, pc, tbr, ac, m_pc[11:0], m_tbr[3:0], m_ac[3:0]);
        end
    endtask

    // compare the result of the previous cycle, then apply new stimulus
    task automatic drive(input logic r, input logic inc, input logic jmp, input logic call,
                         input logic ret, input logic tj, input logic tr,
                         input logic [11:0] tgt, input logic [11:0] rad, input logic [7:0] rom);
        @(negedge clk);
        compare();
        last_req = req;
        rst = r; inc_en = inc; jmp_en = jmp; call_en = call; ret_en = ret;
        tjmp_en = tj; trtn_en = tr; tgt_addr = tgt; ret_addr = rad; rom_data = rom;
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 0, 0, 0, 12'h000, 12'h000, 8'h00);
    endtask

    initial begin
        rst = 1'b1; inc_en = 0; jmp_en = 0; call_en = 0; ret_en = 0;
        tjmp_en = 0; trtn_en = 0; tgt_addr = '0; ret_addr = '0; rom_data = '0;
        repeat (2) @(posedge clk);

        req = "R1";  idle();                        // reset state checked next
        req = "R2";  repeat (5) drive(0,1,0,0,0,0,0, 12'h000, 12'h000, 8'h00);
        req = "R10"; repeat (3) idle();
        req = "R3";  drive(0,0,1,0,0,0,0, 12'h7FD, 12'h000, 8'h00);
        repeat (4) drive(0,1,0,0,0,0,0, 12'h000, 12'h000, 8'h00);
        req = "R4";  drive(0,0,1,0,0,0,0, 12'hFFE, 12'h000, 8'h00);
        req = "R3";  repeat (3) drive(0,1,0,0,0,0,0, 12'h000, 12'h000, 8'h00);
        req = "R5";  drive(0,0,0,1,0,0,0, 12'h123, 12'h000, 8'h00);
        drive(0,0,1,0,0,0,0, 12'h200, 12'h000, 8'h00);
        drive(0,0,0,1,0,0,0, 12'hABC, 12'h000, 8'h00);
        req = "R6";  drive(0,0,0,0,1,0,0, 12'h000, 12'h9A7, 8'h00);
        drive(0,0,0,0,1,0,0, 12'h000, 12'h456, 8'h00);
        req = "R8";  drive(0,0,0,0,0,0,1, 12'h000, 12'h000, 8'hA5);
        req = "R7";  drive(0,0,0,0,0,1,0, 12'h000, 12'h000, 8'h00);
        drive(0,0,1,0,0,0,0, 12'hE12, 12'h000, 8'h00);
        drive(0,0,0,0,0,1,1, 12'h000, 12'h000, 8'h3C);  // uses old pair
        drive(0,0,0,0,0,1,0, 12'h000, 12'h000, 8'h00);
        req = "R9";  drive(0,1,1,1,1,1,0, 12'h111, 12'h222, 8'h00);
        drive(0,1,1,1,0,1,0, 12'h933, 12'h000, 8'h00);
        drive(0,1,0,1,0,1,0, 12'h0F4, 12'h000, 8'h00);
        drive(0,1,0,0,0,1,0, 12'h000, 12'h000, 8'h00);
        req = "R1";  drive(1,1,1,1,1,1,1, 12'hFFF, 12'hFFF, 8'hFF);
        req = "R10"; repeat (2) idle();
        req = "R9";
        for (int i = 0; i < 3000; i++) begin
            logic [9:0] r;
            r = 10'($urandom);
            drive((i % 500) == 499, r[0], r[1] & r[2], r[3] & r[4], r[5] & r[6] & r[7],
                  r[8], r[9], 12'($urandom), 12'($urandom), 8'($urandom));
        end
        idle();
        @(negedge clk);
        compare();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule